// File: doc/BRIEF.md
# Bus Cycle Strobe and Input Synchronizer

This block turns a fast oscillator clock into the timing that surrounds an 8-bit processor's bus cycles. A divide-by-nine phase sequencer produces two processor clock phases that never overlap. It also produces two internal one-count timing pulses: an early pulse at the first count of phase 1 and a late pulse at the last count of phase 2. The early pulse qualifies the processor's cycle-start signal and forms an active-low status strobe. The strobe marks the point in each machine cycle where the status byte on the data bus has settled.

Two slow or asynchronous requests are resampled only on the late phase-2 pulse. The first is an active-low wait request, which becomes the READY level for the processor. The second is an active-low reset request, which has already been cleaned up and can come from a power-on ramp or a switch to ground. It becomes an active-high processor RESET. While that RESET is high, the status strobe is held low without a break, so a bus controller attached to the strobe line also sees a reset and needs no pin of its own for it.

Every output comes from a register on the oscillator clock. Counts are numbered 0 to 8 inside each processor period. Count 0 is the oscillator period that begins at the edge where phase 1 rises. The first edge after `rst_ni` is released enters count 1.

Top module: `bus_cycle_conditioner`

## Requirements
- R1: While `rst_ni` is low, the outputs are `strobe_no`=0, `cpu_reset_o`=1, `ready_o`=0, `phi1_o`=1 and `phi2_o`=0.
- R2: The processor period is 9 oscillator clocks. `phi1_o` is high for counts 0 and 1, and `phi2_o` is high for counts 3 through 7. The two phases are never high together.
- R3: When `cpu_reset_o` is low, `strobe_no` goes low for exactly one oscillator period, at count 0, if `sync_i` was 1 at the clock edge that enters count 0. It stays high at every other count, whatever `sync_i` does then.
- R4: `strobe_no` is low in every oscillator period in which `cpu_reset_o` is high.
- R5: `ready_o` changes only at the edge that enters count 7. At that edge it takes the value of `wait_ni`: 1 means ready and 0 means wait. A change of `wait_ni` at any other edge has no effect on `ready_o`.
- R6: `cpu_reset_o` changes only at the edge that enters count 7. At that edge it loads the inverse of `res_req_ni`, so a low request gives a high RESET. A change of `res_req_ni` at any other edge has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| sync_i | input | 1 | Processor cycle-start indication |
| wait_ni | input | 1 | Asynchronous ready request: 0 asks for a wait state |
| res_req_ni | input | 1 | Conditioned active-low reset request |
| phi1_o | output | 1 | Processor clock phase 1 |
| phi2_o | output | 1 | Processor clock phase 2 |
| strobe_no | output | 1 | Active-low status strobe |
| ready_o | output | 1 | Synchronized READY for the processor |
| cpu_reset_o | output | 1 | Synchronized active-high processor RESET |

## Verification
The assertions check four things on every clock. The two phases never overlap. The strobe falls only on the early pulse or when RESET rises. The strobe is low whenever RESET is high. READY and RESET move only on the late phase-2 pulse, and RESET rises only after a low request was sampled. The bench scenarios are needed for the rest. They show the exact phase widths and the single strobe per SYNC cycle with its count-0 placement. They also show that glitches on the wait and reset requests between sample points leave the outputs unchanged, and that the strobe is held low through whole reset periods.

// File: rtl/cyc_cond_pkg.sv
package cyc_cond_pkg;

  typedef struct packed {
    logic phi1;
    logic phi2;
    logic t1;   // early phase-1 pulse
    logic t2;   // late phase-2 pulse
  } phase_t;

  function automatic logic in_win(int unsigned c, int unsigned s, int unsigned l);
    return (c >= s) && (c < s + l);
  endfunction

  function automatic phase_t decode(int unsigned c, int unsigned p1s, int unsigned p1l,
                                    int unsigned p2s, int unsigned p2l);
    phase_t p;
    p.phi1 = in_win(c, p1s, p1l);
    p.phi2 = in_win(c, p2s, p2l);
    p.t1   = (c == p1s);
    p.t2   = (c == p2s + p2l - 1);
    return p;
  endfunction

endpackage

// File: rtl/cyc_phase_seq.sv
module cyc_phase_seq
  import cyc_cond_pkg::*;
#(
  parameter int unsigned DIV      = 9,
  parameter int unsigned P1_START = 0,
  parameter int unsigned P1_LEN   = 2,
  parameter int unsigned P2_START = 3,
  parameter int unsigned P2_LEN   = 5
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_t ph_o,
  output logic   t1_nxt_o,
  output logic   t2_nxt_o
);
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned LAST = DIV - 1;
  localparam phase_t RST_PH = decode(0, P1_START, P1_LEN, P2_START, P2_LEN);

  logic [CW-1:0] cnt_q, cnt_nxt;
  phase_t        ph_nxt;

  always_comb begin
    cnt_nxt = (cnt_q == CW'(LAST)) ? '0 : cnt_q + 1'b1;
    ph_nxt  = decode(32'(cnt_nxt), P1_START, P1_LEN, P2_START, P2_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_o  <= RST_PH;
    end else begin
      cnt_q <= cnt_nxt;
      ph_o  <= ph_nxt;
    end
  end

  assign t1_nxt_o = ph_nxt.t1;
  assign t2_nxt_o = ph_nxt.t2;

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ph_o.phi1 && ph_o.phi2));

endmodule

// File: rtl/cyc_sample_bank.sv
module cyc_sample_bank #(
  parameter int unsigned     W       = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,   // late pulse about to start
  input  logic         pulse_i,  // late pulse, registered
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_nxt_o,
  output logic [W-1:0] q_o
);
  assign d_nxt_o = load_i ? d_i : q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_nxt_o;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    a_r5_r6_move_on_t2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(q_o[i]) |-> pulse_i);
  end

endmodule

// File: rtl/cyc_strobe_gen.sv
module cyc_strobe_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic t1_nxt_i,
  input  logic t1_i,
  input  logic hold_nxt_i,
  input  logic hold_i,
  output logic strobe_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_no <= 1'b0;
    else         strobe_no <= ~((t1_nxt_i & sync_i) | hold_nxt_i);
  end

  a_r4_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !strobe_no);

  a_r3_fall_on_t1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_no) |-> (t1_i || hold_i));

endmodule

// File: rtl/bus_cycle_conditioner.sv
module bus_cycle_conditioner
  import cyc_cond_pkg::*;
#(
  parameter int unsigned DIV      = 9,
  parameter int unsigned P1_START = 0,
  parameter int unsigned P1_LEN   = 2,
  parameter int unsigned P2_START = 3,
  parameter int unsigned P2_LEN   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic wait_ni,
  input  logic res_req_ni,
  output logic phi1_o,
  output logic phi2_o,
  output logic strobe_no,
  output logic ready_o,
  output logic cpu_reset_o
);
  localparam int unsigned NSMP = 2;
  localparam int unsigned RDY  = 0;
  localparam int unsigned RES  = 1;

  phase_t            ph;
  logic              t1_nxt, t2_nxt;
  logic [NSMP-1:0]   smp_d, smp_nxt, smp_q;

  cyc_phase_seq #(
    .DIV(DIV), .P1_START(P1_START), .P1_LEN(P1_LEN),
    .P2_START(P2_START), .P2_LEN(P2_LEN)
  ) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_o     (ph),
    .t1_nxt_o (t1_nxt),
    .t2_nxt_o (t2_nxt)
  );

  assign smp_d[RDY] = wait_ni;
  assign smp_d[RES] = ~res_req_ni;

  cyc_sample_bank #(.W(NSMP), .RST_VAL(NSMP'(1) << RES)) u_smp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (t2_nxt),
    .pulse_i (ph.t2),
    .d_i     (smp_d),
    .d_nxt_o (smp_nxt),
    .q_o     (smp_q)
  );

  cyc_strobe_gen u_stb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .t1_nxt_i   (t1_nxt),
    .t1_i       (ph.t1),
    .hold_nxt_i (smp_nxt[RES]),
    .hold_i     (smp_q[RES]),
    .strobe_no  (strobe_no)
  );

  assign phi1_o      = ph.phi1;
  assign phi2_o      = ph.phi2;
  assign ready_o     = smp_q[RDY];
  assign cpu_reset_o = smp_q[RES];

  a_r6_reset_from_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_reset_o) |-> !$past(res_req_ni));

endmodule

// File: tb/bus_cycle_conditioner_bench.sv
module bus_cycle_conditioner_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sync = 1'b0, wait_n = 1'b1, res_n = 1'b1;
  logic phi1, phi2, strobe_n, ready, cpu_reset;

  always #4 clk = ~clk;

  bus_cycle_conditioner u_bus_cycle_conditioner (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .wait_ni(wait_n), .res_req_ni(res_n),
    .phi1_o(phi1), .phi2_o(phi2), .strobe_no(strobe_n), .ready_o(ready),
    .cpu_reset_o(cpu_reset)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // bench-side count model: count after each edge since reset release
  int bc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) bc <= 0;
    else        bc <= (bc == 8) ? 0 : bc + 1;

  typedef struct {
    logic sync, rp, rn, yp, yn;
    int   lows;
  } exp_t;
  exp_t q[$];

  int   lows, p1c, p2c, ovl;
  logic s0, y6, r6;
  bit   act;

  // monitor: collects one processor period, then compares with the scoreboard
  always @(negedge clk) if (rst_n) begin
    exp_t e;
    if (bc == 0) begin
      lows = 0; p1c = 0; p2c = 0; ovl = 0; s0 = strobe_n;
    end
    lows += int'(!strobe_n);
    p1c  += int'(phi1);
    p2c  += int'(phi2);
    if (phi1 && phi2) ovl++;
    if (cpu_reset) chk(!strobe_n, "R4 strobe low during reset", int'(strobe_n), 0);
    if (bc == 1) act = (q.size() > 0);
    if (bc == 6) begin y6 = ready; r6 = cpu_reset; end
    if (bc == 8 && act) begin
      e = q.pop_front();
      chk(lows == e.lows, "R3/R4 strobe low count", lows, e.lows);
      chk(s0 == !(e.sync | e.rp), "R3 strobe at count 0", int'(s0), int'(!(e.sync | e.rp)));
      chk(y6 == e.yp, "R5 ready held before sample", int'(y6), int'(e.yp));
      chk(ready == e.yn, "R5 ready after sample", int'(ready), int'(e.yn));
      chk(r6 == e.rp, "R6 reset held before sample", int'(r6), int'(e.rp));
      chk(cpu_reset == e.rn, "R6 reset after sample", int'(cpu_reset), int'(e.rn));
      chk(p1c == 2, "R2 phi1 width", p1c, 2);
      chk(p2c == 5, "R2 phi2 width", p2c, 5);
      chk(ovl == 0, "R2 phase overlap", ovl, 0);
    end
  end

  logic mrp, myp;

  // driver: one processor period, starting at the negedge of count 8
  task automatic period(logic s, logic w, logic r, bit glitch);
    exp_t e;
    e.sync = s; e.rp = mrp; e.yp = myp; e.rn = !r; e.yn = w;
    e.lows = int'(s | mrp) + 6 * int'(mrp) + 2 * int'(!r);
    q.push_back(e);
    for (int j = 0; j < 9; j++) begin
      sync   = (j <= 2) ? s : 1'b0;
      wait_n = (glitch && j >= 2 && j <= 4) ? !w : w;
      res_n  = (glitch && j >= 2 && j <= 4) ? !r : r;
      @(negedge clk);
    end
    mrp = !r;
    myp = w;
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strobe_n == 0, "R1 strobe in reset", int'(strobe_n), 0);
    chk(cpu_reset == 1, "R1 cpu reset in reset", int'(cpu_reset), 1);
    chk(ready == 0, "R1 ready in reset", int'(ready), 0);
    chk(phi1 == 1, "R1 phi1 in reset", int'(phi1), 1);
    chk(phi2 == 0, "R1 phi2 in reset", int'(phi2), 0);
    rst_n = 1'b1;
    while (bc != 8) @(negedge clk);
    mrp = 1'b0;  // idle request high sampled at first late pulse
    myp = 1'b1;
    period(1, 1, 1, 0);
    period(0, 1, 1, 0);
    period(1, 0, 1, 0);
    period(1, 0, 1, 1);  // R5 R6 glitches ignored
    period(1, 1, 1, 1);
    period(0, 1, 0, 0);  // reset request
    period(1, 1, 0, 1);
    period(0, 1, 1, 0);
    period(1, 1, 1, 0);
    period(0, 0, 1, 1);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    report();
  end

endmodule